// File: doc/BRIEF.md
# ADC Sample Packer with Loss Marking

This block sits between a pair of 12-bit converters and a downstream buffer FIFO. On every rising edge of the sample clock it takes one sample from each channel, together with that channel's over-range and top-half-of-range flags. It formats each sample as a 16-bit half-word and packs two half-words into one 32-bit word. It writes that word into the buffer through a write strobe.

A configuration input picks the packing. In single-channel mode, two consecutive channel A samples share one word. In dual-channel mode, the A and B samples taken on the same edge share one word.

When the buffer reports full, a finished word is dropped instead of stalling. The next half-word that is stored carries a loss marker, so the consumer can see where the gap lies in the stream. Every drop also retriggers an indicator output that stays on for a programmable number of sample clocks. This gives a visible sign that the sample rate is higher than the rate at which the data is read.

Top module: `adc_pack_top`

## Requirements
- R1: Each half-word has this layout: the signed sample in bits 11..0, over-range in bit 12, top-half-used in bit 13, the loss marker in bit 14, and 0 in bit 15. The upper half-word (bits 31..16) uses the same layout.
- R2: With `two_ch_cfg` = 0 (single channel), words are built from channel A only. The sample from the first edge of a pair goes in bits 15..0 and the sample from the second edge goes in bits 31..16. A word is offered on every second edge, counted from reset.
- R3: With `two_ch_cfg` = 1 (dual channel), a word is offered on every edge. Channel A goes in bits 15..0 and channel B in bits 31..16.
- R4: The `two_ch_cfg` encoding is 0 for single channel and 1 for dual channel. A reset empties any half-built word, so pairing starts with the next edge.
- R5: `wr_en` is high for the one cycle after an edge at which a word was completed and `buf_full` was low at that edge, and `wr_data` holds the word during that cycle. If `buf_full` was high at that edge, the word is dropped and no strobe follows.
- R6: After a drop, the next half-words stored carry the loss marker (bit 14 and/or bit 30). In dual-channel mode both halves of the next word carry it. In single-channel mode only the first sample captured afterwards (bits 15..0) carries it. The marker stops once a word is accepted.
- R7: The pending loss mark survives further drops and survives a discarded half-built word. It clears only when a word is accepted.
- R8: `loss_led` rises in the cycle after a drop and stays high for HOLD_CYCLES cycles. Each further drop restarts the full hold period.
- R9: A mode change takes effect at a word boundary. If `two_ch_cfg` goes to 1 while a single-channel word is half-built, the half word and the sample taken at that edge are discarded without a write. Packing then continues in dual-channel mode from the next edge.
- R10: After reset, `wr_en` and `loss_led` are low and no loss mark is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| two_ch_cfg | input | 1 | 0 = single channel, 1 = dual channel |
| cha_smp | input | SMP_W | Channel A signed sample |
| cha_ovr | input | 1 | Channel A over-range flag |
| cha_thu | input | 1 | Channel A top-half-used flag |
| chb_smp | input | SMP_W | Channel B signed sample |
| chb_ovr | input | 1 | Channel B over-range flag |
| chb_thu | input | 1 | Channel B top-half-used flag |
| buf_full | input | 1 | Downstream buffer full flag |
| wr_en | output | 1 | Write strobe into the buffer |
| wr_data | output | 32 | Packed word |
| loss_led | output | 1 | Retriggerable loss indicator |

## Verification
The hardest case is a single-channel drop followed by a mid-word switch to dual-channel mode. The loss mark has already been folded into a stored half-word, and that half-word is then thrown away. The bench reaches this case by holding `buf_full` high at exactly the second edge of a pair and changing `two_ch_cfg` on the edge after the next capture. It then checks that the first dual-channel word still carries the marker in both halves. The indicator hold is tested with a short HOLD_CYCLES, so that the bench can count the high period exactly, both for a single drop and when a second drop retriggers it.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 2 * HALF_W;
  localparam int OVR_BIT  = 12;
  localparam int THU_BIT  = 13;
  localparam int LOSS_BIT = 14;
  localparam int NUM_CH   = 2;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic half_t tag_loss(input half_t h, input logic loss);
    half_t r;
    r = h;
    r[LOSS_BIT] = loss;
    return r;
  endfunction
endpackage

// File: rtl/adc_half_fmt.sv
module adc_half_fmt
  import adc_pack_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic [SMP_W-1:0] smp,
  input  logic             ovr,
  input  logic             thu,
  output half_t            half_o
);
  always_comb begin
    half_o = '0;
    half_o[SMP_W-1:0] = smp;
    half_o[OVR_BIT]   = ovr;
    half_o[THU_BIT]   = thu;
  end
endmodule

// File: rtl/adc_word_builder.sv
module adc_word_builder
  import adc_pack_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mode_cfg,
  input  half_t half_a,
  input  half_t half_b,
  input  logic  buf_full,
  output logic  wr_en,
  output word_t wr_data,
  output logic  drop_o,
  output logic  pend_o,
  output logic  mode_o
);
  logic  phase_q;
  logic  mode_q;
  logic  pend_q;
  half_t lo_q;

  logic  discard;
  logic  mode_eff;
  logic  done;
  logic  capture;
  word_t word;
  half_t a_tag;
  half_t b_tag;

  always_comb begin
    a_tag    = tag_loss(half_a, pend_q);
    b_tag    = tag_loss(half_b, pend_q);
    discard  = phase_q && mode_cfg;
    mode_eff = phase_q ? mode_q : mode_cfg;
    done     = 1'b0;
    capture  = 1'b0;
    word     = '0;
    if (discard) begin
      done = 1'b0;
    end else if (mode_eff) begin
      done = 1'b1;
      word = {b_tag, a_tag};
    end else if (phase_q) begin
      done = 1'b1;
      word = {tag_loss(half_a, 1'b0), lo_q};
    end else begin
      capture = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      mode_q  <= 1'b0;
      pend_q  <= 1'b0;
      lo_q    <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en  <= done && !buf_full;
      mode_q <= discard ? mode_cfg : mode_eff;
      if (done && !buf_full) wr_data <= word;
      if (done) pend_q <= buf_full;
      if (capture) lo_q <= a_tag;
      phase_q <= capture;
    end
  end

  assign drop_o = done && buf_full;
  assign pend_o = pend_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/adc_loss_hold.sv
module adc_loss_hold #(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic drop,
  output logic led
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      led   <= 1'b0;
    end else if (drop) begin
      cnt_q <= HOLD_LD;
      led   <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      led <= (cnt_q > CNT_W'(1));
    end
  end
endmodule

// File: rtl/adc_pack_top.sv
module adc_pack_top
  import adc_pack_pkg::*;
#(
  parameter int SMP_W       = 12,
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             two_ch_cfg,
  input  logic [SMP_W-1:0] cha_smp,
  input  logic             cha_ovr,
  input  logic             cha_thu,
  input  logic [SMP_W-1:0] chb_smp,
  input  logic             chb_ovr,
  input  logic             chb_thu,
  input  logic             buf_full,
  output logic             wr_en,
  output logic [31:0]      wr_data,
  output logic             loss_led
);
  logic [SMP_W-1:0] smp_arr [NUM_CH];
  logic             ovr_arr [NUM_CH];
  logic             thu_arr [NUM_CH];
  half_t            half_arr[NUM_CH];

  logic drop_w;
  logic pend_w;
  logic mode_w;

  assign smp_arr[0] = cha_smp;
  assign smp_arr[1] = chb_smp;
  assign ovr_arr[0] = cha_ovr;
  assign ovr_arr[1] = chb_ovr;
  assign thu_arr[0] = cha_thu;
  assign thu_arr[1] = chb_thu;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_fmt
    adc_half_fmt #(.SMP_W(SMP_W)) u_fmt (
      .smp    (smp_arr[g]),
      .ovr    (ovr_arr[g]),
      .thu    (thu_arr[g]),
      .half_o (half_arr[g])
    );
  end

  adc_word_builder u_build (
    .clk      (clk),
    .rst      (rst),
    .mode_cfg (two_ch_cfg),
    .half_a   (half_arr[0]),
    .half_b   (half_arr[1]),
    .buf_full (buf_full),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .drop_o   (drop_w),
    .pend_o   (pend_w),
    .mode_o   (mode_w)
  );

  adc_loss_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .drop (drop_w),
    .led  (loss_led)
  );
endmodule

// File: rtl/adc_pack_chk.sv
module adc_pack_chk (
  input logic        clk,
  input logic        rst,
  input logic        buf_full,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        loss_led,
  input logic        drop,
  input logic        pend,
  input logic        mode
);
  // R1
  zero_pad_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!wr_data[15] && !wr_data[31]));

  // R5
  accept_on_space_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(buf_full));

  // R5
  no_strobe_after_drop_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> !wr_en);

  // R8
  led_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> loss_led);

  // R7
  pend_after_drop_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> pend);

  // R6
  dual_loss_match_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode) |-> (wr_data[14] == wr_data[30]));
endmodule

bind adc_pack_top adc_pack_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .buf_full (buf_full),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .loss_led (loss_led),
  .drop     (drop_w),
  .pend     (pend_w),
  .mode     (mode_w)
);

// File: tb/adc_pack_top_tb.sv
`timescale 1ns/1ps
module adc_pack_top_tb;
  localparam int HOLD = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        two_ch_cfg = 1'b0;
  logic [11:0] cha_smp = '0, chb_smp = '0;
  logic        cha_ovr = 1'b0, cha_thu = 1'b0, chb_ovr = 1'b0, chb_thu = 1'b0;
  logic        buf_full = 1'b0;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        loss_led;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_pack_top #(.SMP_W(12), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst(rst), .two_ch_cfg(two_ch_cfg),
    .cha_smp(cha_smp), .cha_ovr(cha_ovr), .cha_thu(cha_thu),
    .chb_smp(chb_smp), .chb_ovr(chb_ovr), .chb_thu(chb_thu),
    .buf_full(buf_full), .wr_en(wr_en), .wr_data(wr_data), .loss_led(loss_led)
  );

  function automatic logic [15:0] hw(input logic [11:0] d, input logic o,
                                     input logic t, input logic l);
    return {1'b0, l, t, o, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; buf_full = 1'b0; two_ch_cfg = 1'b0;
    cha_smp = '0; chb_smp = '0;
    cha_ovr = 0; cha_thu = 0; chb_ovr = 0; chb_thu = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic push(input logic [11:0] a, input logic [11:0] b, input logic full);
    cha_smp = a; chb_smp = b; buf_full = full;
    @(posedge clk); #1;
    buf_full = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 wr_en", {31'd0, wr_en}, 32'd0);
    chk("R10 led", {31'd0, loss_led}, 32'd0);
    two_ch_cfg = 1;
    push(12'h001, 12'h002, 1'b1);
    do_reset();
    two_ch_cfg = 1;
    push(12'h003, 12'h004, 1'b0);
    chk("R10 no pending mark", wr_data, {hw(12'h004,0,0,0), hw(12'h003,0,0,0)});
  endtask

  task automatic t_one_ch();
    do_reset();
    two_ch_cfg = 0;
    push(12'h101, 12'hAAA, 0);
    chk("R2 no write after first", {31'd0, wr_en}, 32'd0);
    push(12'h102, 12'hBBB, 0);
    chk("R2 write after pair", {31'd0, wr_en}, 32'd1);
    chk("R2 pair order", wr_data, {hw(12'h102,0,0,0), hw(12'h101,0,0,0)});
    push(12'hF03, 12'h0, 0);
    chk("R2 idle mid-pair", {31'd0, wr_en}, 32'd0);
    push(12'h804, 12'h0, 0);
    chk("R2 second pair", wr_data, {hw(12'h804,0,0,0), hw(12'hF03,0,0,0)});
  endtask

  task automatic t_two_ch();
    do_reset();
    two_ch_cfg = 1;
    for (int i = 0; i < 3; i++) begin
      push(12'(16 + i), 12'(32 + i), 0);
      chk("R3 strobe each edge", {31'd0, wr_en}, 32'd1);
      chk("R3 A low B high", wr_data, {hw(12'(32 + i),0,0,0), hw(12'(16 + i),0,0,0)});
    end
  endtask

  task automatic t_flags();
    do_reset();
    two_ch_cfg = 1;
    cha_ovr = 1; chb_thu = 1;
    push(12'h800, 12'h7FF, 0);
    chk("R1 layout", wr_data, {hw(12'h7FF,0,1,0), hw(12'h800,1,0,0)});
    cha_ovr = 0; chb_thu = 0; cha_thu = 1; chb_ovr = 1;
    push(12'hFFF, 12'h000, 0);
    chk("R1 layout swapped flags", wr_data, {hw(12'h000,1,0,0), hw(12'hFFF,0,1,0)});
    chk("R1 pad bits", {30'd0, wr_data[31], wr_data[15]}, 32'd0);
    cha_thu = 0; chb_ovr = 0;
  endtask

  task automatic t_drop_two();
    do_reset();
    two_ch_cfg = 1;
    push(12'h011, 12'h022, 1);
    chk("R5 dropped no strobe", {31'd0, wr_en}, 32'd0);
    chk("R8 led after drop", {31'd0, loss_led}, 32'd1);
    push(12'h033, 12'h044, 0);
    chk("R6 both halves marked", wr_data, {hw(12'h044,0,0,1), hw(12'h033,0,0,1)});
    push(12'h055, 12'h066, 0);
    chk("R6 mark cleared", wr_data, {hw(12'h066,0,0,0), hw(12'h055,0,0,0)});
  endtask

  task automatic t_drop_one();
    do_reset();
    two_ch_cfg = 0;
    push(12'h201, 0, 0);
    push(12'h202, 0, 1);
    chk("R5 one-ch drop", {31'd0, wr_en}, 32'd0);
    push(12'h203, 0, 0);
    push(12'h204, 0, 0);
    chk("R6 low half only", wr_data, {hw(12'h204,0,0,0), hw(12'h203,0,0,1)});
    push(12'h205, 0, 0);
    push(12'h206, 0, 0);
    chk("R6 one-ch cleared", wr_data, {hw(12'h206,0,0,0), hw(12'h205,0,0,0)});
  endtask

  task automatic t_multi_drop();
    do_reset();
    two_ch_cfg = 1;
    push(12'h301, 12'h302, 1);
    push(12'h303, 12'h304, 1);
    chk("R7 still no strobe", {31'd0, wr_en}, 32'd0);
    push(12'h305, 12'h306, 0);
    chk("R7 mark after two drops", wr_data, {hw(12'h306,0,0,1), hw(12'h305,0,0,1)});
    do_reset();
    two_ch_cfg = 0;
    push(12'h401, 0, 0);
    push(12'h402, 0, 1);
    push(12'h403, 0, 0);
    two_ch_cfg = 1;
    push(12'h404, 12'h405, 0);
    chk("R9 discard no write", {31'd0, wr_en}, 32'd0);
    push(12'h406, 12'h407, 0);
    chk("R7 mark survives discard", wr_data, {hw(12'h407,0,0,1), hw(12'h406,0,0,1)});
  endtask

  task automatic t_mode_switch();
    do_reset();
    two_ch_cfg = 0;
    push(12'h501, 0, 0);
    two_ch_cfg = 1;
    push(12'h502, 12'h503, 0);
    chk("R9 mid-word switch no write", {31'd0, wr_en}, 32'd0);
    push(12'h504, 12'h505, 0);
    chk("R9 dual after switch", wr_data, {hw(12'h505,0,0,0), hw(12'h504,0,0,0)});
    chk("R4 dual strobe", {31'd0, wr_en}, 32'd1);
    two_ch_cfg = 0;
    push(12'h506, 12'h5FF, 0);
    chk("R4 single at boundary", {31'd0, wr_en}, 32'd0);
    push(12'h507, 12'h5FF, 0);
    chk("R4 single word", wr_data, {hw(12'h507,0,0,0), hw(12'h506,0,0,0)});
  endtask

  task automatic t_led_hold();
    int on_bad;
    do_reset();
    two_ch_cfg = 1;
    push(0, 0, 1);
    on_bad = 0;
    for (int i = 1; i < HOLD; i++) begin
      if (loss_led !== 1'b1) on_bad++;
      push(0, 0, 0);
    end
    chk("R8 held for period", on_bad, 0);
    chk("R8 still on last cycle", {31'd0, loss_led}, 32'd1);
    push(0, 0, 0);
    chk("R8 off after period", {31'd0, loss_led}, 32'd0);
    push(0, 0, 1);
    for (int i = 0; i < 10; i++) push(0, 0, 0);
    push(0, 0, 1);
    on_bad = 0;
    for (int i = 1; i < HOLD; i++) begin
      if (loss_led !== 1'b1) on_bad++;
      push(0, 0, 0);
    end
    chk("R8 retrigger extends", on_bad + {31'd0, ~loss_led}, 0);
    push(0, 0, 0);
    chk("R8 off after retrigger", {31'd0, loss_led}, 32'd0);
  endtask

  initial begin
    t_reset_state();
    t_one_ch();
    t_two_ch();
    t_flags();
    t_drop_two();
    t_drop_one();
    t_multi_drop();
    t_mode_switch();
    t_led_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule